// File: doc/BRIEF.md
# Serial NOR Flash Operation Sequencer

This block runs complete serial NOR flash operations on its own, so that a host only has to issue a request and wait. A request carries an operation select, a 24-bit address, a byte length and a limit on status reads. The sequencer turns the request into one or more chip-select bursts on a byte-level SPI transaction interface. An external shift engine moves each byte when `txStart` pulses and answers with `rxDone` and the byte it received. Bytes for a page program arrive on a valid/ready input stream. Bytes read from the device leave on a valid-only output stream.

Operations that change the array are composite. The block sends write enable as a separate burst. For a program it then waits for the device to go idle. It sends the command itself and finally polls the status register until the busy bit clears. Completion is reported with a one-cycle `done` pulse. `opError` is raised in that same cycle when the status-poll limit ran out. While an operation runs, `busy` stays high and any further request is dropped.

Top module: `flash_op_sequencer`

## Requirements
- R1: After reset and while idle, `busy`, `done`, `csActive`, `txStart`, `rdValid` and `opError` are low.
- R2: Read (reqOp 2) sends one burst: 0x03, then the three address bytes most significant first, then reqLen dummy bytes. Each received payload byte appears on `rdData` with a one-cycle `rdValid`, in order.
- R3: Identification (reqOp 0) sends 0x9F and streams the 4 bytes that follow. Unique identification (reqOp 1) sends 0x4B and streams the 12 bytes that follow.
- R4: Page program (reqOp 3) sends a 0x06 burst and polls until idle. It then sends 0x02, the three address bytes and min(reqLen, PAGE_BYTES) bytes taken from the write stream, and then polls until idle.
- R5: Sector erase (reqOp 4) sends a 0x06 burst, then 0x20 with the three address bytes, then polls. Chip erase (reqOp 5) sends 0x06, then the single byte 0xC7, then polls.
- R6: Write disable (reqOp 6) sends the single byte 0x04 as one burst and does not poll.
- R7: A status poll is a two-byte burst, 0x05 followed by one read byte. It is repeated while bit 0 of the read byte is 1, and the phase ends at the first read with bit 0 equal to 0.
- R8: When reqMaxPolls status reads in one poll phase all show bit 0 set, the operation ends and `opError` is high with `done`. A value of 0 acts as 1. Otherwise `opError` stays low.
- R9: `csActive` drops for at least one cycle between bursts. `txStart` is only issued while `csActive` is high. At most one byte is outstanding, so no new `txStart` comes before `rxDone`.
- R10: A request that arrives while `busy` is high has no effect. A request with reqOp 7 is never accepted.
- R11: `busy` rises in the cycle after a request is accepted and stays high up to and including the single cycle in which `done` is high.
- R12: A program data byte is taken only when `wrValid` and `wrReady` are both high. `wrReady` is only high together with `txStart`, and a gap in `wrValid` holds the burst without ending it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe, taken only while idle |
| reqOp | input | 3 | Operation select (0 id, 1 unique id, 2 read, 3 program, 4 sector erase, 5 chip erase, 6 write disable) |
| reqAddr | input | 24 | Flash byte address |
| reqLen | input | 9 | Payload length for read and program |
| reqMaxPolls | input | 8 | Maximum status reads per poll phase |
| wrData | input | 8 | Program data byte |
| wrValid | input | 1 | Program data available |
| wrReady | output | 1 | Program data byte consumed this cycle |
| rdData | output | 8 | Read data byte |
| rdValid | output | 1 | Read data byte valid |
| csActive | output | 1 | Chip select asserted (high = selected) |
| txByte | output | 8 | Byte for the shift engine, valid with txStart |
| txStart | output | 1 | Starts one byte transfer |
| rxByte | input | 8 | Byte received by the shift engine |
| rxDone | input | 1 | Byte transfer finished, rxByte valid |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| opError | output | 1 | Poll limit exhausted, valid with done |

## Verification
The hardest situation to reach is the poll limit. It needs a device that keeps reporting busy for more status reads than the request allows, which a well-behaved flash rarely does. The bench's flash model holds a busy countdown that is loaded when a program or erase burst ends. A test loads it with 50 and requests a limit of 4. Stalls in the program stream are forced by gating `wrValid` with a free-running counter, so that the burst must hold with chip select still asserted.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    OP_READ_ID       = 3'd0,
    OP_READ_UID      = 3'd1,
    OP_READ          = 3'd2,
    OP_PROGRAM       = 3'd3,
    OP_SECTOR_ERASE  = 3'd4,
    OP_CHIP_ERASE    = 3'd5,
    OP_WRITE_DISABLE = 3'd6,
    OP_RESERVED      = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    PH_WREN    = 2'd0,
    PH_PREPOLL = 2'd1,
    PH_MAIN    = 2'd2,
    PH_POLL    = 2'd3
  } phase_e;

  localparam logic [7:0] CMD_WREN   = 8'h06;
  localparam logic [7:0] CMD_WRDI   = 8'h04;
  localparam logic [7:0] CMD_STATUS = 8'h05;
  localparam logic [7:0] CMD_READ   = 8'h03;
  localparam logic [7:0] CMD_PROG   = 8'h02;
  localparam logic [7:0] CMD_SERASE = 8'h20;
  localparam logic [7:0] CMD_CERASE = 8'hC7;
  localparam logic [7:0] CMD_ID     = 8'h9F;
  localparam logic [7:0] CMD_UID    = 8'h4B;

  // control -> datapath
  typedef struct packed {
    phase_e phase;
    logic   latchReq;
    logic   startBurst;
    logic   advanceByte;
    logic   captureRx;
    logic   clearPoll;
    logic   stepPoll;
    logic   flagError;
  } seq_strobe_t;

  // datapath -> control
  typedef struct packed {
    op_e  op;
    logic lastByte;
    logic writePayload;
    logic deviceBusy;
    logic pollSpent;
  } seq_status_t;

  function automatic logic needsWren(op_e op);
    return (op == OP_PROGRAM) || (op == OP_SECTOR_ERASE) || (op == OP_CHIP_ERASE);
  endfunction

endpackage

// File: rtl/flash_seq_datapath.sv
module flash_seq_datapath
  import flash_seq_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int LEN_W      = 9,
  parameter int PAGE_BYTES = 256,
  parameter int POLL_W     = 8,
  parameter int ID_BYTES   = 4,
  parameter int UID_BYTES  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  seq_strobe_t             strobe,
  input  logic [2:0]              reqOp,
  input  logic [8*ADDR_BYTES-1:0] reqAddr,
  input  logic [LEN_W-1:0]        reqLen,
  input  logic [POLL_W-1:0]       reqMaxPolls,
  input  logic [7:0]              wrData,
  input  logic [7:0]              rxByte,
  output logic [7:0]              txByte,
  output logic [7:0]              rdData,
  output logic                    rdValid,
  output logic                    errFlag,
  output seq_status_t             status
);

  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int IDX_W  = LEN_W + 2;

  op_e                 opReg;
  logic [ADDR_W-1:0]   addrReg;
  logic [LEN_W-1:0]    lenReg;
  logic [POLL_W-1:0]   maxPollReg;
  logic [POLL_W-1:0]   pollCnt;
  logic [IDX_W-1:0]    byteIdx;
  logic [7:0]          statusReg;
  logic [7:0]          rdDataReg;
  logic                rdValidReg;
  logic                errReg;

  logic [IDX_W-1:0]    hdrLen;
  logic [IDX_W-1:0]    payloadLen;
  logic [IDX_W-1:0]    progLen;
  logic [IDX_W-1:0]    burstLen;
  logic [7:0]          opcode;
  logic                inPayload;
  logic                readStream;
  logic                pollPhase;
  logic                writePayload;
  logic [ADDR_W-1:0]   addrShifted;

  assign progLen = (IDX_W'(lenReg) > IDX_W'(PAGE_BYTES)) ? IDX_W'(PAGE_BYTES) : IDX_W'(lenReg);
  assign pollPhase = (strobe.phase == PH_PREPOLL) || (strobe.phase == PH_POLL);
  assign readStream = (strobe.phase == PH_MAIN) &&
                      ((opReg == OP_READ_ID) || (opReg == OP_READ_UID) || (opReg == OP_READ));

  always_comb begin
    hdrLen     = IDX_W'(1);
    payloadLen = '0;
    opcode     = CMD_WREN;
    case (strobe.phase)
      PH_WREN: opcode = CMD_WREN;
      PH_PREPOLL, PH_POLL: begin
        opcode     = CMD_STATUS;
        payloadLen = IDX_W'(1);
      end
      default: begin
        case (opReg)
          OP_READ_ID: begin
            opcode     = CMD_ID;
            payloadLen = IDX_W'(ID_BYTES);
          end
          OP_READ_UID: begin
            opcode     = CMD_UID;
            payloadLen = IDX_W'(UID_BYTES);
          end
          OP_READ: begin
            opcode     = CMD_READ;
            hdrLen     = IDX_W'(1 + ADDR_BYTES);
            payloadLen = IDX_W'(lenReg);
          end
          OP_PROGRAM: begin
            opcode     = CMD_PROG;
            hdrLen     = IDX_W'(1 + ADDR_BYTES);
            payloadLen = progLen;
          end
          OP_SECTOR_ERASE: begin
            opcode = CMD_SERASE;
            hdrLen = IDX_W'(1 + ADDR_BYTES);
          end
          OP_CHIP_ERASE: opcode = CMD_CERASE;
          default:       opcode = CMD_WRDI;
        endcase
      end
    endcase
  end

  assign burstLen     = hdrLen + payloadLen;
  assign inPayload    = byteIdx >= hdrLen;
  assign writePayload = inPayload && (strobe.phase == PH_MAIN) && (opReg == OP_PROGRAM);
  assign addrShifted  = addrReg >> (8 * (ADDR_BYTES - int'(byteIdx)));

  always_comb begin
    if (byteIdx == '0)      txByte = opcode;
    else if (!inPayload)    txByte = addrShifted[7:0];
    else if (writePayload)  txByte = wrData;
    else                    txByte = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opReg      <= OP_READ_ID;
      addrReg    <= '0;
      lenReg     <= '0;
      maxPollReg <= '0;
      pollCnt    <= '0;
      byteIdx    <= '0;
      statusReg  <= '0;
      rdDataReg  <= '0;
      rdValidReg <= 1'b0;
      errReg     <= 1'b0;
    end else begin
      if (strobe.latchReq) begin
        opReg      <= op_e'(reqOp);
        addrReg    <= reqAddr;
        lenReg     <= reqLen;
        maxPollReg <= reqMaxPolls;
        errReg     <= 1'b0;
      end
      if (strobe.startBurst)       byteIdx <= '0;
      else if (strobe.advanceByte) byteIdx <= byteIdx + 1'b1;
      if (strobe.clearPoll)        pollCnt <= '0;
      else if (strobe.stepPoll)    pollCnt <= pollCnt + 1'b1;
      rdValidReg <= 1'b0;
      if (strobe.captureRx && inPayload) begin
        if (readStream) begin
          rdDataReg  <= rxByte;
          rdValidReg <= 1'b1;
        end
        if (pollPhase) statusReg <= rxByte;
      end
      if (strobe.flagError) errReg <= 1'b1;
    end
  end

  assign rdData              = rdDataReg;
  assign rdValid             = rdValidReg;
  assign errFlag             = errReg;
  assign status.op           = opReg;
  assign status.lastByte     = (byteIdx == burstLen - 1'b1);
  assign status.writePayload = writePayload;
  assign status.deviceBusy   = statusReg[0];
  assign status.pollSpent    = ({1'b0, pollCnt} + 1'b1) >= {1'b0, maxPollReg};

endmodule

// File: rtl/flash_seq_control.sv
module flash_seq_control
  import flash_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic [2:0]  reqOp,
  input  logic        wrValid,
  input  logic        rxDone,
  input  seq_status_t status,
  output seq_strobe_t strobe,
  output logic        csActive,
  output logic        txStart,
  output logic        wrReady,
  output logic        busy,
  output logic        done
);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_SEND = 3'd1,
    S_WAIT = 3'd2,
    S_END  = 3'd3,
    S_DONE = 3'd4
  } state_e;

  state_e state, stateNext;
  phase_e phase, phaseNext;

  always_comb begin
    stateNext    = state;
    phaseNext    = phase;
    strobe       = '0;
    strobe.phase = phase;
    csActive     = 1'b0;
    txStart      = 1'b0;
    wrReady      = 1'b0;
    case (state)
      S_IDLE: begin
        if (reqValid && (reqOp != OP_RESERVED)) begin
          strobe.latchReq   = 1'b1;
          strobe.startBurst = 1'b1;
          phaseNext = needsWren(op_e'(reqOp)) ? PH_WREN : PH_MAIN;
          stateNext = S_SEND;
        end
      end
      S_SEND: begin
        csActive = 1'b1;
        if (!status.writePayload || wrValid) begin
          txStart   = 1'b1;
          wrReady   = status.writePayload;
          stateNext = S_WAIT;
        end
      end
      S_WAIT: begin
        csActive = 1'b1;
        if (rxDone) begin
          strobe.captureRx = 1'b1;
          if (status.lastByte) begin
            stateNext = S_END;
          end else begin
            strobe.advanceByte = 1'b1;
            stateNext = S_SEND;
          end
        end
      end
      S_END: begin
        case (phase)
          PH_WREN: begin
            strobe.startBurst = 1'b1;
            strobe.clearPoll  = 1'b1;
            phaseNext = (status.op == OP_PROGRAM) ? PH_PREPOLL : PH_MAIN;
            stateNext = S_SEND;
          end
          PH_MAIN: begin
            if (needsWren(status.op)) begin
              strobe.startBurst = 1'b1;
              strobe.clearPoll  = 1'b1;
              phaseNext = PH_POLL;
              stateNext = S_SEND;
            end else begin
              stateNext = S_DONE;
            end
          end
          default: begin
            if (!status.deviceBusy) begin
              if (phase == PH_PREPOLL) begin
                strobe.startBurst = 1'b1;
                phaseNext = PH_MAIN;
                stateNext = S_SEND;
              end else begin
                stateNext = S_DONE;
              end
            end else if (status.pollSpent) begin
              strobe.flagError = 1'b1;
              stateNext = S_DONE;
            end else begin
              strobe.stepPoll   = 1'b1;
              strobe.startBurst = 1'b1;
              stateNext = S_SEND;
            end
          end
        endcase
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      phase <= PH_MAIN;
    end else begin
      state <= stateNext;
      phase <= phaseNext;
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

endmodule

// File: rtl/flash_op_sequencer.sv
module flash_op_sequencer
  import flash_seq_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int LEN_W      = 9,
  parameter int PAGE_BYTES = 256,
  parameter int POLL_W     = 8,
  parameter int ID_BYTES   = 4,
  parameter int UID_BYTES  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reqValid,
  input  logic [2:0]              reqOp,
  input  logic [8*ADDR_BYTES-1:0] reqAddr,
  input  logic [LEN_W-1:0]        reqLen,
  input  logic [POLL_W-1:0]       reqMaxPolls,
  input  logic [7:0]              wrData,
  input  logic                    wrValid,
  output logic                    wrReady,
  output logic [7:0]              rdData,
  output logic                    rdValid,
  output logic                    csActive,
  output logic [7:0]              txByte,
  output logic                    txStart,
  input  logic [7:0]              rxByte,
  input  logic                    rxDone,
  output logic                    busy,
  output logic                    done,
  output logic                    opError
);

  seq_strobe_t strobe;
  seq_status_t status;
  logic        errFlag;

  flash_seq_control u_control (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .wrValid  (wrValid),
    .rxDone   (rxDone),
    .status   (status),
    .strobe   (strobe),
    .csActive (csActive),
    .txStart  (txStart),
    .wrReady  (wrReady),
    .busy     (busy),
    .done     (done)
  );

  flash_seq_datapath #(
    .ADDR_BYTES (ADDR_BYTES),
    .LEN_W      (LEN_W),
    .PAGE_BYTES (PAGE_BYTES),
    .POLL_W     (POLL_W),
    .ID_BYTES   (ID_BYTES),
    .UID_BYTES  (UID_BYTES)
  ) u_datapath (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .reqOp       (reqOp),
    .reqAddr     (reqAddr),
    .reqLen      (reqLen),
    .reqMaxPolls (reqMaxPolls),
    .wrData      (wrData),
    .rxByte      (rxByte),
    .txByte      (txByte),
    .rdData      (rdData),
    .rdValid     (rdValid),
    .errFlag     (errFlag),
    .status      (status)
  );

  assign opError = done & errFlag;

endmodule

// File: rtl/flash_seq_checker.sv
module flash_seq_checker (
  input logic clk,
  input logic rst_n,
  input logic csActive,
  input logic txStart,
  input logic rxDone,
  input logic wrReady,
  input logic wrValid,
  input logic busy,
  input logic done,
  input logic opError
);

  logic txPending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       txPending <= 1'b0;
    else if (txStart) txPending <= 1'b1;
    else if (rxDone)  txPending <= 1'b0;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!csActive && !txStart && !opError));

  // R8
  error_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opError |-> done);

  // R9
  start_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txStart |-> csActive);

  // R9
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txStart |-> !txPending);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R12
  write_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrReady |-> (wrValid && txStart));

endmodule

bind flash_op_sequencer flash_seq_checker u_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .csActive (csActive),
  .txStart  (txStart),
  .rxDone   (rxDone),
  .wrReady  (wrReady),
  .wrValid  (wrValid),
  .busy     (busy),
  .done     (done),
  .opError  (opError)
);

// File: tb/flash_op_sequencer_bench.sv
`timescale 1ns/1ps
module flash_op_sequencer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqOp = '0;
  logic [23:0] reqAddr = '0;
  logic [8:0]  reqLen = '0;
  logic [7:0]  reqMaxPolls = 8'd200;
  logic [7:0]  wrData;
  logic        wrValid;
  logic        wrReady;
  logic [7:0]  rdData;
  logic        rdValid;
  logic        csActive;
  logic [7:0]  txByte;
  logic        txStart;
  logic [7:0]  rxByte;
  logic        rxDone;
  logic        busy;
  logic        done;
  logic        opError;

  always #2 clk = ~clk;

  flash_op_sequencer u_flash_op_sequencer (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqLen(reqLen), .reqMaxPolls(reqMaxPolls), .wrData(wrData), .wrValid(wrValid),
    .wrReady(wrReady), .rdData(rdData), .rdValid(rdValid), .csActive(csActive),
    .txByte(txByte), .txStart(txStart), .rxByte(rxByte), .rxDone(rxDone),
    .busy(busy), .done(done), .opError(opError)
  );

  int nChecks = 0;
  int nFails  = 0;

  // stimulus-side settings, written only by the main sequence
  logic       logClear = 1'b0;
  int         busyLoad = 0;
  int         wrN = 0;
  bit         stallMode = 1'b0;
  logic [7:0] wrSrc [0:511];

  // flash model and monitors, written only by the always block below
  logic [7:0] mem [0:255];
  logic [7:0] bOp [0:31];
  int         bLen [0:31];
  logic [7:0] bAddr [0:31][0:2];
  int         nBursts, pos, busyLeft, weViolations, wrIdx, rdCnt, lat;
  logic [7:0] curOp, addrLo, resp;
  logic [7:0] rdBuf [0:63];
  bit         wel, pend, prevCs;
  logic [3:0] freeCnt;

  assign wrValid = (wrIdx < wrN) && (!stallMode || freeCnt[1]);
  assign wrData  = wrSrc[wrIdx[8:0]];

  always @(posedge clk) begin
    logic [7:0] b, idx8;
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
      nBursts = 0; pos = 0; busyLeft = 0; weViolations = 0; wrIdx <= 0; rdCnt = 0;
      wel = 0; pend = 0; prevCs = 0; lat = 0; curOp = 0; addrLo = 0;
      rxDone <= 1'b0; rxByte <= 8'h00; freeCnt <= '0;
    end else begin
      freeCnt <= freeCnt + 1'b1;
      if (logClear) begin
        nBursts = 0; weViolations = 0; rdCnt = 0; busyLeft = 0;
        wrIdx <= 0;
      end
      if (wrReady && wrValid) wrIdx <= wrIdx + 1;
      if (rdValid && rdCnt < 64) begin
        rdBuf[rdCnt] = rdData;
        rdCnt++;
      end
      rxDone <= 1'b0;
      if (pend) begin
        if (lat == 0) begin
          rxDone <= 1'b1;
          rxByte <= resp;
          pend = 0;
        end else lat--;
      end
      if (prevCs && !csActive) begin
        if (nBursts < 32) bLen[nBursts] = pos;
        if (curOp == 8'h02 || curOp == 8'h20 || curOp == 8'hC7) begin
          if (!wel) weViolations++;
          wel = 0;
          busyLeft = busyLoad;
          if (curOp != 8'h02) for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
        end
        if (curOp == 8'h06) wel = 1;
        if (curOp == 8'h04) wel = 0;
        nBursts++;
        pos = 0;
      end
      prevCs = csActive;
      if (txStart) begin
        b = txByte;
        resp = 8'h00;
        if (pos == 0) begin
          curOp = b;
          if (nBursts < 32) bOp[nBursts] = b;
        end
        if (pos >= 1 && pos <= 3 && nBursts < 32) bAddr[nBursts][pos-1] = b;
        if (pos == 3) addrLo = b;
        idx8 = addrLo + 8'(pos - 4);
        case (curOp)
          8'h9F: if (pos >= 1) resp = 8'hC0 + 8'(pos);
          8'h4B: if (pos >= 1) resp = 8'h40 + 8'(pos);
          8'h03: if (pos >= 4) resp = mem[idx8];
          8'h02: if (pos >= 4) mem[idx8] = b;
          8'h05: if (pos == 1) begin
            resp = (busyLeft > 0) ? 8'h01 : 8'h00;
            if (busyLeft > 0) busyLeft--;
          end
          default: resp = 8'h00;
        endcase
        pos++;
        pend = 1;
        lat = 2;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic clearLog();
    @(negedge clk) logClear = 1'b1;
    @(negedge clk) logClear = 1'b0;
  endtask

  task automatic startOp(input logic [2:0] op, input logic [23:0] addr,
                         input logic [8:0] len, input logic [7:0] maxp);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = addr; reqLen = len; reqMaxPolls = maxp;
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy == 1'b1, "R11 busy after accept", int'(busy), 1);
  endtask

  task automatic waitDone(input string tag, output bit err);
    int n = 0;
    err = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, tag, int'(done), 1);
    err = opError;
    @(negedge clk);
    chk(!busy && !done, "R11 idle after done", int'({busy, done}), 0);
  endtask

  task automatic expectBurst(input int k, input logic [7:0] op, input int len, input string tag);
    chk(bOp[k] == op, tag, int'(bOp[k]), int'(op));
    chk(bLen[k] == len, tag, bLen[k], len);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !csActive && !txStart && !rdValid && !opError,
        "R1 reset outputs", int'({busy, done, csActive, txStart, rdValid, opError}), 0);
  endtask

  task automatic t_ids();
    bit err;
    clearLog();
    startOp(3'd0, 24'h0, 9'd0, 8'd200);
    waitDone("R3 id done", err);
    chk(nBursts == 1, "R3 id burst count", nBursts, 1);
    expectBurst(0, 8'h9F, 5, "R3 id burst");
    chk(rdCnt == 4, "R3 id byte count", rdCnt, 4);
    for (int i = 0; i < 4; i++) chk(rdBuf[i] == 8'hC1 + 8'(i), "R3 id data", int'(rdBuf[i]), 'hC1 + i);
    clearLog();
    startOp(3'd1, 24'h0, 9'd0, 8'd200);
    waitDone("R3 uid done", err);
    expectBurst(0, 8'h4B, 13, "R3 uid burst");
    chk(rdCnt == 12, "R3 uid byte count", rdCnt, 12);
    for (int i = 0; i < 12; i++) chk(rdBuf[i] == 8'h41 + 8'(i), "R3 uid data", int'(rdBuf[i]), 'h41 + i);
  endtask

  task automatic t_read();
    bit err;
    clearLog();
    startOp(3'd2, 24'h123410, 9'd6, 8'd200);
    waitDone("R2 read done", err);
    chk(nBursts == 1, "R2 read burst count", nBursts, 1);
    expectBurst(0, 8'h03, 10, "R2 read burst");
    chk({bAddr[0][0], bAddr[0][1], bAddr[0][2]} == 24'h123410, "R2 address order",
        int'({bAddr[0][0], bAddr[0][1], bAddr[0][2]}), 'h123410);
    chk(rdCnt == 6, "R2 read byte count", rdCnt, 6);
    for (int i = 0; i < 6; i++) chk(rdBuf[i] == mem[8'h10 + 8'(i)], "R2 read data", int'(rdBuf[i]), int'(mem[8'h10 + 8'(i)]));
  endtask

  task automatic t_program();
    bit err;
    for (int i = 0; i < 512; i++) wrSrc[i] = 8'h90 + 8'(i);
    busyLoad = 3; stallMode = 1'b1; wrN = 5;
    clearLog();
    startOp(3'd3, 24'h000020, 9'd5, 8'd200);
    waitDone("R4 program done", err);
    chk(nBursts == 7, "R4 R7 program burst count", nBursts, 7);
    expectBurst(0, 8'h06, 1, "R4 write enable");
    expectBurst(1, 8'h05, 2, "R4 R7 pre-poll");
    expectBurst(2, 8'h02, 9, "R4 program burst");
    for (int k = 3; k < 7; k++) expectBurst(k, 8'h05, 2, "R7 busy poll");
    chk(weViolations == 0, "R4 enable before program", weViolations, 0);
    chk(err == 1'b0, "R8 no error", int'(err), 0);
    chk(wrIdx == 5, "R12 bytes taken with stalls", wrIdx, 5);
    for (int i = 0; i < 5; i++) chk(mem[8'h20 + 8'(i)] == wrSrc[i], "R12 programmed data", int'(mem[8'h20 + 8'(i)]), int'(wrSrc[i]));
    // length above one page is clamped
    busyLoad = 0; stallMode = 1'b0; wrN = 300;
    clearLog();
    startOp(3'd3, 24'h000000, 9'd400, 8'd200);
    waitDone("R4 clamp done", err);
    expectBurst(2, 8'h02, 260, "R4 page clamp");
    chk(wrIdx == 256, "R4 clamp bytes taken", wrIdx, 256);
    wrN = 0;
  endtask

  task automatic t_erase();
    bit err;
    busyLoad = 2;
    clearLog();
    startOp(3'd4, 24'h0ABCDE, 9'd0, 8'd200);
    waitDone("R5 sector done", err);
    chk(nBursts == 5, "R5 sector burst count", nBursts, 5);
    expectBurst(0, 8'h06, 1, "R5 sector enable");
    expectBurst(1, 8'h20, 4, "R5 sector cmd");
    chk({bAddr[1][0], bAddr[1][1], bAddr[1][2]} == 24'h0ABCDE, "R5 sector address",
        int'({bAddr[1][0], bAddr[1][1], bAddr[1][2]}), 'h0ABCDE);
    expectBurst(4, 8'h05, 2, "R5 R7 sector poll");
    chk(weViolations == 0, "R5 enable before erase", weViolations, 0);
    busyLoad = 0;
    clearLog();
    startOp(3'd5, 24'h0, 9'd0, 8'd200);
    waitDone("R5 chip done", err);
    chk(nBursts == 3, "R5 chip burst count", nBursts, 3);
    expectBurst(0, 8'h06, 1, "R5 chip enable");
    expectBurst(1, 8'hC7, 1, "R5 chip cmd");
    expectBurst(2, 8'h05, 2, "R5 chip poll");
  endtask

  task automatic t_wrdis();
    bit err;
    clearLog();
    startOp(3'd6, 24'h0, 9'd0, 8'd200);
    waitDone("R6 disable done", err);
    chk(nBursts == 1, "R6 single burst", nBursts, 1);
    expectBurst(0, 8'h04, 1, "R6 disable cmd");
  endtask

  task automatic t_pollLimit();
    bit err;
    busyLoad = 50;
    clearLog();
    startOp(3'd4, 24'h000100, 9'd0, 8'd4);
    waitDone("R8 limit done", err);
    chk(err == 1'b1, "R8 error flag", int'(err), 1);
    chk(nBursts == 6, "R8 poll count at limit", nBursts, 6);
    busyLoad = 0;
    clearLog();
    startOp(3'd6, 24'h0, 9'd0, 8'd200);
    waitDone("R8 error cleared done", err);
    chk(err == 1'b0, "R8 error cleared", int'(err), 0);
  endtask

  task automatic t_ignore();
    bit err;
    clearLog();
    startOp(3'd0, 24'h0, 9'd0, 8'd200);
    @(negedge clk);
    reqValid = 1'b1; reqOp = 3'd5;
    repeat (3) @(negedge clk);
    reqValid = 1'b0;
    waitDone("R10 done", err);
    repeat (4) @(negedge clk);
    chk(nBursts == 1 && bOp[0] == 8'h9F, "R10 request while busy", nBursts, 1);
    chk(!busy, "R10 no late start", int'(busy), 0);
    reqValid = 1'b1; reqOp = 3'd7;
    @(negedge clk);
    reqValid = 1'b0;
    chk(!busy, "R10 reserved op", int'(busy), 0);
    repeat (6) @(negedge clk);
    chk(nBursts == 1 && !csActive, "R10 reserved op no burst", nBursts, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ids();
    t_read();
    t_program();
    t_erase();
    t_wrdis();
    t_pollLimit();
    t_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule